// File: doc/BRIEF.md
# Microcode Sequencer with Encoded Jump Logic

This block is the control unit of a small microprogrammed processor. A micro-program counter (uPC) addresses a control store written as a synthesizable case table. Each control-store entry holds a 17-bit control word for the datapath, a 3-bit jump type and an absolute micro-address. The next uPC comes from the jump type together with the memory busy flag, the datapath zero flag and a dispatch table indexed by the 6-bit macro opcode.

The store holds the routines for instruction fetch, register ALU operations, ALU with immediate, load word, store word, branch-if-zero, branch-if-not-zero, jump, and jump-and-link. The datapath and its register file, the memory and exception handling all sit outside this block. The control word leaves the block as a flat vector, and the datapath decodes it with the field layout given in R7.

Top module: `ucodeSequencer`

## Requirements
- R1: While `rstN` is low, uPC is held at micro-address 0, which is the first fetch step. `ctrlOut` then shows the fetch step-0 word (MA gets PC).
- R2: Jump type "next" loads uPC+1.
- R3: Jump type "spin" keeps uPC unchanged while `busy` is 1 and advances to uPC+1 when `busy` is 0. In every other state `busy` has no effect.
- R4: Jump type "fetch" loads micro-address 0.
- R5: Jump type "dispatch" loads the routine start for the opcode held on `opcode`. The opcodes are 0x00 register ALU, 0x08 ALU immediate, 0x23 load, 0x2B store, 0x04 branch-if-zero, 0x05 branch-if-not-zero, 0x02 jump and 0x03 jump-and-link. Every other opcode value returns to fetch.
- R6: Jump type "feqz" loads the absolute address when `zero` is 1 and uPC+1 otherwise. Jump type "fnez" loads uPC+1 when `zero` is 1 and the absolute address otherwise.
- R7: The control word has this layout: bit16 load IR, bit15 load A, bit14 load B, bit13 load MA, [12:10] register select (0 rs, 1 rt, 2 rd, 3 PC, 4 link register 31), bit9 register write, bit8 register drives bus, [7:6] immediate select (0 off, 1 sign-extended 16-bit, 2 sign-extended and shifted left by 2, 3 jump field of IR; any nonzero value drives the bus), [5:3] ALU op (0 A+B, 1 A+4, 2 pass A, 3 function from IR, 4 jump target), bit2 ALU drives bus, bit1 memory enable, bit0 memory write. At most one of register, immediate, ALU and memory read (enable without write) drives the bus in any step.
- R8: Fetch runs four steps: MA gets PC; IR gets memory, with spin; A gets PC; PC gets A+4, with dispatch.
- R9: A register ALU operation runs A gets rs, B gets rt, rd gets func(A,B), then fetch. An ALU-immediate operation runs A gets rs, B gets the sign-extended immediate, rt gets op(A,B), then fetch.
- R10: A load runs A gets rs, B gets the sign-extended immediate, MA gets A+B, rt gets memory (spin), then an idle step that jumps to fetch. A store is the same except that its fourth step writes rt to memory.
- R11: Both branches read A from rs and then run an idle test step (fnez for branch-if-zero, feqz for branch-if-not-zero, with the absolute address 0). On the taken path they run A gets PC, B gets the shifted immediate, PC gets A+B, then fetch.
- R12: A jump runs A gets PC, B gets the IR jump field, PC gets the jump target, then fetch. Jump-and-link runs A gets PC, register 31 gets A, B gets the IR jump field, PC gets the jump target, then fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Macro opcode from IR |
| zero | input | 1 | Datapath zero flag |
| busy | input | 1 | Memory busy flag |
| ctrlOut | output | 17 | Datapath control word (layout in R7) |

## Verification
The checker watches the sequencing rules on every cycle. It checks uPC+1 on "next", hold or advance on "spin" according to `busy`, the return to address 0 on "fetch", the table address on "dispatch", the zero-dependent choice on the two branch jump types, and the single-bus-driver rule on each control word. Whether each routine issues the right transfers in the right order can only be shown by the bench. The bench sweeps all 64 opcodes under both values of `zero` and under varying memory wait lengths, and compares every control word against a sequence it builds from the requirements.

// File: rtl/ucodePkg.sv
package ucodePkg;
  parameter int UADDR_W = 6;
  parameter int OP_W    = 6;
  parameter int CTRL_W  = 17;

  typedef enum logic [2:0] {RS_RS, RS_RT, RS_RD, RS_PC, RS_LINK} regSel_e;
  typedef enum logic [1:0] {IMM_OFF, IMM_SEXT, IMM_SEXT_SH2, IMM_JFIELD} immSel_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_INC4, ALU_PASSA, ALU_FUNC, ALU_JTARG} aluOp_e;
  typedef enum logic [2:0] {JT_NEXT, JT_SPIN, JT_FETCH, JT_DISPATCH, JT_FEQZ, JT_FNEZ} jump_e;

  typedef struct packed {
    logic    ldIR;
    logic    ldA;
    logic    ldB;
    logic    ldMA;
    regSel_e regSel;
    logic    regWrt;
    logic    enReg;
    immSel_e immSel;
    aluOp_e  aluOp;
    logic    enALU;
    logic    enMem;
    logic    memWrt;
  } ctrlWord_t;

  typedef struct packed {
    ctrlWord_t            ctrl;
    jump_e                jump;
    logic [UADDR_W-1:0]   absAddr;
  } storeEntry_t;

  // Routine start addresses in the control store
  localparam int A_FETCH = 0;
  localparam int A_ALU   = 4;
  localparam int A_ALUI  = 7;
  localparam int A_LW    = 10;
  localparam int A_SW    = 15;
  localparam int A_BEQZ  = 20;
  localparam int A_BNEZ  = 25;
  localparam int A_J     = 30;
  localparam int A_JAL   = 33;

  // Macro opcodes
  localparam logic [OP_W-1:0] OP_ALU  = 6'h00;
  localparam logic [OP_W-1:0] OP_ALUI = 6'h08;
  localparam logic [OP_W-1:0] OP_LW   = 6'h23;
  localparam logic [OP_W-1:0] OP_SW   = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQZ = 6'h04;
  localparam logic [OP_W-1:0] OP_BNEZ = 6'h05;
  localparam logic [OP_W-1:0] OP_J    = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL  = 6'h03;

  function automatic ctrlWord_t cw(logic ldIR, logic ldA, logic ldB, logic ldMA,
                                   regSel_e rs, logic regWrt, logic enReg,
                                   immSel_e imm, aluOp_e alu, logic enALU,
                                   logic enMem, logic memWrt);
    ctrlWord_t c;
    c.ldIR = ldIR; c.ldA = ldA; c.ldB = ldB; c.ldMA = ldMA;
    c.regSel = rs; c.regWrt = regWrt; c.enReg = enReg;
    c.immSel = imm; c.aluOp = alu; c.enALU = enALU;
    c.enMem = enMem; c.memWrt = memWrt;
    return c;
  endfunction

  function automatic storeEntry_t ent(ctrlWord_t c, jump_e j, int abs);
    storeEntry_t e;
    e.ctrl = c;
    e.jump = j;
    e.absAddr = UADDR_W'(abs);
    return e;
  endfunction

  // Frequently used transfers
  function automatic ctrlWord_t regToA(regSel_e s);
    return cw(1'b0, 1'b1, 1'b0, 1'b0, s, 1'b0, 1'b1, IMM_OFF, ALU_ADD, 1'b0, 1'b0, 1'b0);
  endfunction

  function automatic ctrlWord_t immToB(immSel_e s);
    return cw(1'b0, 1'b0, 1'b1, 1'b0, RS_RS, 1'b0, 1'b0, s, ALU_ADD, 1'b0, 1'b0, 1'b0);
  endfunction

  function automatic ctrlWord_t aluToReg(aluOp_e op, regSel_e s);
    return cw(1'b0, 1'b0, 1'b0, 1'b0, s, 1'b1, 1'b0, IMM_OFF, op, 1'b1, 1'b0, 1'b0);
  endfunction

  localparam ctrlWord_t CW_IDLE = '0;
endpackage

// File: rtl/ucodeStore.sv
module ucodeStore
  import ucodePkg::*;
(
  input  logic [UADDR_W-1:0] uAddr,
  output storeEntry_t        entry
);
  always_comb begin
    case (int'(uAddr))
      // instruction fetch
      A_FETCH+0: entry = ent(cw(1'b0, 1'b0, 1'b0, 1'b1, RS_PC, 1'b0, 1'b1, IMM_OFF, ALU_ADD, 1'b0, 1'b0, 1'b0), JT_NEXT, 0);
      A_FETCH+1: entry = ent(cw(1'b1, 1'b0, 1'b0, 1'b0, RS_RS, 1'b0, 1'b0, IMM_OFF, ALU_ADD, 1'b0, 1'b1, 1'b0), JT_SPIN, 0);
      A_FETCH+2: entry = ent(regToA(RS_PC), JT_NEXT, 0);
      A_FETCH+3: entry = ent(aluToReg(ALU_INC4, RS_PC), JT_DISPATCH, 0);
      // register ALU
      A_ALU+0:   entry = ent(regToA(RS_RS), JT_NEXT, 0);
      A_ALU+1:   entry = ent(cw(1'b0, 1'b0, 1'b1, 1'b0, RS_RT, 1'b0, 1'b1, IMM_OFF, ALU_ADD, 1'b0, 1'b0, 1'b0), JT_NEXT, 0);
      A_ALU+2:   entry = ent(aluToReg(ALU_FUNC, RS_RD), JT_FETCH, 0);
      // ALU immediate
      A_ALUI+0:  entry = ent(regToA(RS_RS), JT_NEXT, 0);
      A_ALUI+1:  entry = ent(immToB(IMM_SEXT), JT_NEXT, 0);
      A_ALUI+2:  entry = ent(aluToReg(ALU_FUNC, RS_RT), JT_FETCH, 0);
      // load word
      A_LW+0:    entry = ent(regToA(RS_RS), JT_NEXT, 0);
      A_LW+1:    entry = ent(immToB(IMM_SEXT), JT_NEXT, 0);
      A_LW+2:    entry = ent(cw(1'b0, 1'b0, 1'b0, 1'b1, RS_RS, 1'b0, 1'b0, IMM_OFF, ALU_ADD, 1'b1, 1'b0, 1'b0), JT_NEXT, 0);
      A_LW+3:    entry = ent(cw(1'b0, 1'b0, 1'b0, 1'b0, RS_RT, 1'b1, 1'b0, IMM_OFF, ALU_ADD, 1'b0, 1'b1, 1'b0), JT_SPIN, 0);
      A_LW+4:    entry = ent(CW_IDLE, JT_FETCH, 0);
      // store word
      A_SW+0:    entry = ent(regToA(RS_RS), JT_NEXT, 0);
      A_SW+1:    entry = ent(immToB(IMM_SEXT), JT_NEXT, 0);
      A_SW+2:    entry = ent(cw(1'b0, 1'b0, 1'b0, 1'b1, RS_RS, 1'b0, 1'b0, IMM_OFF, ALU_ADD, 1'b1, 1'b0, 1'b0), JT_NEXT, 0);
      A_SW+3:    entry = ent(cw(1'b0, 1'b0, 1'b0, 1'b0, RS_RT, 1'b0, 1'b1, IMM_OFF, ALU_ADD, 1'b0, 1'b1, 1'b1), JT_SPIN, 0);
      A_SW+4:    entry = ent(CW_IDLE, JT_FETCH, 0);
      // branch if zero
      A_BEQZ+0:  entry = ent(regToA(RS_RS), JT_NEXT, 0);
      A_BEQZ+1:  entry = ent(CW_IDLE, JT_FNEZ, A_FETCH);
      A_BEQZ+2:  entry = ent(regToA(RS_PC), JT_NEXT, 0);
      A_BEQZ+3:  entry = ent(immToB(IMM_SEXT_SH2), JT_NEXT, 0);
      A_BEQZ+4:  entry = ent(aluToReg(ALU_ADD, RS_PC), JT_FETCH, 0);
      // branch if not zero
      A_BNEZ+0:  entry = ent(regToA(RS_RS), JT_NEXT, 0);
      A_BNEZ+1:  entry = ent(CW_IDLE, JT_FEQZ, A_FETCH);
      A_BNEZ+2:  entry = ent(regToA(RS_PC), JT_NEXT, 0);
      A_BNEZ+3:  entry = ent(immToB(IMM_SEXT_SH2), JT_NEXT, 0);
      A_BNEZ+4:  entry = ent(aluToReg(ALU_ADD, RS_PC), JT_FETCH, 0);
      // jump
      A_J+0:     entry = ent(regToA(RS_PC), JT_NEXT, 0);
      A_J+1:     entry = ent(immToB(IMM_JFIELD), JT_NEXT, 0);
      A_J+2:     entry = ent(aluToReg(ALU_JTARG, RS_PC), JT_FETCH, 0);
      // jump and link
      A_JAL+0:   entry = ent(regToA(RS_PC), JT_NEXT, 0);
      A_JAL+1:   entry = ent(aluToReg(ALU_PASSA, RS_LINK), JT_NEXT, 0);
      A_JAL+2:   entry = ent(immToB(IMM_JFIELD), JT_NEXT, 0);
      A_JAL+3:   entry = ent(aluToReg(ALU_JTARG, RS_PC), JT_FETCH, 0);
      default:   entry = ent(CW_IDLE, JT_FETCH, 0);
    endcase
  end
endmodule

// File: rtl/ucodeDispatch.sv
module ucodeDispatch
  import ucodePkg::*;
(
  input  logic [OP_W-1:0]    opcode,
  output logic [UADDR_W-1:0] dispAddr
);
  always_comb begin
    case (opcode)
      OP_ALU:  dispAddr = UADDR_W'(A_ALU);
      OP_ALUI: dispAddr = UADDR_W'(A_ALUI);
      OP_LW:   dispAddr = UADDR_W'(A_LW);
      OP_SW:   dispAddr = UADDR_W'(A_SW);
      OP_BEQZ: dispAddr = UADDR_W'(A_BEQZ);
      OP_BNEZ: dispAddr = UADDR_W'(A_BNEZ);
      OP_J:    dispAddr = UADDR_W'(A_J);
      OP_JAL:  dispAddr = UADDR_W'(A_JAL);
      default: dispAddr = UADDR_W'(A_FETCH);
    endcase
  end
endmodule

// File: rtl/ucodeNextAddr.sv
module ucodeNextAddr
  import ucodePkg::*;
(
  input  logic [UADDR_W-1:0] uPC,
  input  jump_e              jumpType,
  input  logic [UADDR_W-1:0] absAddr,
  input  logic [UADDR_W-1:0] dispAddr,
  input  logic               zero,
  input  logic               busy,
  output logic [UADDR_W-1:0] nextPC
);
  logic [UADDR_W-1:0] incPC;
  assign incPC = uPC + 1'b1;

  always_comb begin
    case (jumpType)
      JT_NEXT:     nextPC = incPC;
      JT_SPIN:     nextPC = busy ? uPC : incPC;
      JT_FETCH:    nextPC = UADDR_W'(A_FETCH);
      JT_DISPATCH: nextPC = dispAddr;
      JT_FEQZ:     nextPC = zero ? absAddr : incPC;
      JT_FNEZ:     nextPC = zero ? incPC : absAddr;
      default:     nextPC = UADDR_W'(A_FETCH);
    endcase
  end
endmodule

// File: rtl/ucodeSequencer.sv
module ucodeSequencer
  import ucodePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic              zero,
  input  logic              busy,
  output logic [CTRL_W-1:0] ctrlOut
);
  logic [UADDR_W-1:0] uPC;
  logic [UADDR_W-1:0] nextPC;
  logic [UADDR_W-1:0] dispAddr;
  storeEntry_t        entry;

  ucodeStore u_store (
    .uAddr (uPC),
    .entry (entry)
  );

  ucodeDispatch u_disp (
    .opcode   (opcode),
    .dispAddr (dispAddr)
  );

  ucodeNextAddr u_next (
    .uPC      (uPC),
    .jumpType (entry.jump),
    .absAddr  (entry.absAddr),
    .dispAddr (dispAddr),
    .zero     (zero),
    .busy     (busy),
    .nextPC   (nextPC)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uPC <= UADDR_W'(A_FETCH);
    else       uPC <= nextPC;
  end

  assign ctrlOut = entry.ctrl;
endmodule

// File: rtl/ucodeSequencerChk.sv
module ucodeSequencerChk
  import ucodePkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               zero,
  input logic               busy,
  input logic [UADDR_W-1:0] uPC,
  input jump_e              jumpType,
  input logic [UADDR_W-1:0] absAddr,
  input logic [UADDR_W-1:0] dispAddr,
  input ctrlWord_t          ctrl
);
  AST_NEXT_INC: assert property (@(posedge clk) disable iff (!rstN)
    jumpType == JT_NEXT |=> uPC == UADDR_W'($past(uPC) + 1'b1)); // R2

  AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (jumpType == JT_SPIN && busy) |=> $stable(uPC)); // R3

  AST_SPIN_GO: assert property (@(posedge clk) disable iff (!rstN)
    (jumpType == JT_SPIN && !busy) |=> uPC == UADDR_W'($past(uPC) + 1'b1)); // R3

  AST_FETCH_RET: assert property (@(posedge clk) disable iff (!rstN)
    jumpType == JT_FETCH |=> uPC == UADDR_W'(A_FETCH)); // R4

  AST_DISPATCH_TGT: assert property (@(posedge clk) disable iff (!rstN)
    jumpType == JT_DISPATCH |=> uPC == $past(dispAddr)); // R5

  AST_FEQZ_SEL: assert property (@(posedge clk) disable iff (!rstN)
    jumpType == JT_FEQZ |=> uPC == ($past(zero) ? $past(absAddr) : UADDR_W'($past(uPC) + 1'b1))); // R6

  AST_FNEZ_SEL: assert property (@(posedge clk) disable iff (!rstN)
    jumpType == JT_FNEZ |=> uPC == ($past(zero) ? UADDR_W'($past(uPC) + 1'b1) : $past(absAddr))); // R6

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctrl.enReg, ctrl.enALU, ctrl.immSel != IMM_OFF, ctrl.enMem && !ctrl.memWrt}) <= 1); // R7

  AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memWrt |-> ctrl.enMem); // R7
endmodule

bind ucodeSequencer ucodeSequencerChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .zero     (zero),
  .busy     (busy),
  .uPC      (uPC),
  .jumpType (entry.jump),
  .absAddr  (entry.absAddr),
  .dispAddr (dispAddr),
  .ctrl     (entry.ctrl)
);

// File: tb/ucodeSequencer_bench.sv
`timescale 1ns/1ps
module ucodeSequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  opcode = '0;
  logic        zero = 1'b0;
  logic        busy = 1'b0;
  logic [16:0] ctrlOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ucodeSequencer u_ucodeSequencer (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .zero    (zero),
    .busy    (busy),
    .ctrlOut (ctrlOut)
  );

  // Field layout per R7
  function automatic logic [16:0] w(input logic ldIR, ldA, ldB, ldMA, input logic [2:0] rsel,
                                    input logic rw, er, input logic [1:0] imm,
                                    input logic [2:0] alu, input logic ea, em, mw);
    return {ldIR, ldA, ldB, ldMA, rsel, rw, er, imm, alu, ea, em, mw};
  endfunction

  function automatic logic [16:0] regToA(input logic [2:0] s);
    return w(0, 1, 0, 0, s, 0, 1, 2'd0, 3'd0, 0, 0, 0);
  endfunction
  function automatic logic [16:0] immToB(input logic [1:0] s);
    return w(0, 0, 1, 0, 3'd0, 0, 0, s, 3'd0, 0, 0, 0);
  endfunction
  function automatic logic [16:0] aluTo(input logic [2:0] op, input logic [2:0] s);
    return w(0, 0, 0, 0, s, 1, 0, 2'd0, op, 1, 0, 0);
  endfunction

  logic [16:0] F0, F1, F2, F3, RTB, MAADD, LW3, SW3, IDLE;
  initial begin
    F0    = w(0, 0, 0, 1, 3'd3, 0, 1, 2'd0, 3'd0, 0, 0, 0);
    F1    = w(1, 0, 0, 0, 3'd0, 0, 0, 2'd0, 3'd0, 0, 1, 0);
    F2    = regToA(3'd3);
    F3    = aluTo(3'd1, 3'd3);
    RTB   = w(0, 0, 1, 0, 3'd1, 0, 1, 2'd0, 3'd0, 0, 0, 0);
    MAADD = w(0, 0, 0, 1, 3'd0, 0, 0, 2'd0, 3'd0, 1, 0, 0);
    LW3   = w(0, 0, 0, 0, 3'd1, 1, 0, 2'd0, 3'd0, 0, 1, 0);
    SW3   = w(0, 0, 0, 0, 3'd1, 0, 1, 2'd0, 3'd0, 0, 1, 1);
    IDLE  = '0;
  end

  // Compare the current word, set busy for the coming edge, advance one cycle
  task automatic step(input logic [16:0] exp, input logic b, input string tag);
    int drivers;
    compared++;
    if (ctrlOut !== exp) begin
      mismatched++;
      $display("FAIL %s: ctrlOut=%05h expected=%05h (opcode=%02h zero=%0b)", tag, ctrlOut, exp, opcode, zero);
    end
    drivers = int'(ctrlOut[8]) + int'(ctrlOut[2]) + int'(ctrlOut[7:6] != 2'd0) + int'(ctrlOut[1] && !ctrlOut[0]);
    compared++;
    if (drivers > 1) begin
      mismatched++;
      $display("FAIL R7: bus drivers=%0d expected<=1 word=%05h", drivers, ctrlOut);
    end
    busy = b;
    @(negedge clk);
  endtask

  task automatic spinStep(input logic [16:0] exp, input int nb, input string tag);
    for (int i = 0; i < nb; i++) step(exp, 1'b1, tag);
    step(exp, 1'b0, tag);
  endtask

  task automatic runInstr(input logic [5:0] op, input logic z, input int nb, input logic noise, input string f0tag);
    opcode = op;
    zero = z;
    step(F0, noise, f0tag);
    spinStep(F1, nb, "R3 fetch memory wait");
    step(F2, noise, "R2 fetch A<-PC");
    step(F3, noise, "R8 fetch PC<-A+4");
    case (op)
      6'h00: begin
        step(regToA(3'd0), noise, "R5 dispatch ALU A<-rs");
        step(RTB, noise, "R9 ALU B<-rt");
        step(aluTo(3'd3, 3'd2), noise, "R9 ALU rd<-func");
      end
      6'h08: begin
        step(regToA(3'd0), noise, "R5 dispatch ALUI A<-rs");
        step(immToB(2'd1), noise, "R9 ALUI B<-sext");
        step(aluTo(3'd3, 3'd1), noise, "R9 ALUI rt<-op");
      end
      6'h23, 6'h2B: begin
        step(regToA(3'd0), noise, "R5 dispatch mem A<-rs");
        step(immToB(2'd1), noise, "R10 mem B<-sext");
        step(MAADD, noise, "R10 mem MA<-A+B");
        spinStep((op == 6'h23) ? LW3 : SW3, nb, "R10 mem transfer spin");
        step(IDLE, noise, "R10 mem final");
      end
      6'h04, 6'h05: begin
        step(regToA(3'd0), noise, "R5 dispatch branch A<-rs");
        step(IDLE, noise, "R6 branch test");
        if ((op == 6'h04) == z) begin
          step(regToA(3'd3), noise, "R11 taken A<-PC");
          step(immToB(2'd2), noise, "R11 taken B<-imm<<2");
          step(aluTo(3'd0, 3'd3), noise, "R11 taken PC<-A+B");
        end
      end
      6'h02: begin
        step(regToA(3'd3), noise, "R5 dispatch J A<-PC");
        step(immToB(2'd3), noise, "R12 J B<-IR");
        step(aluTo(3'd4, 3'd3), noise, "R12 J PC<-target");
      end
      6'h03: begin
        step(regToA(3'd3), noise, "R5 dispatch JAL A<-PC");
        step(aluTo(3'd2, 3'd4), noise, "R12 JAL r31<-A");
        step(immToB(2'd3), noise, "R12 JAL B<-IR");
        step(aluTo(3'd4, 3'd3), noise, "R12 JAL PC<-target");
      end
      default: ;
    endcase
  endtask

  function automatic bit known(input logic [5:0] op);
    return op inside {6'h00, 6'h08, 6'h23, 6'h2B, 6'h04, 6'h05, 6'h02, 6'h03};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (ctrlOut !== F0) begin
      mismatched++;
      $display("FAIL R1: reset word=%05h expected=%05h", ctrlOut, F0);
    end
    busy = 1'b1;
    @(negedge clk);
    compared++;
    if (ctrlOut !== F0) begin
      mismatched++;
      $display("FAIL R1: word under reset with busy=%05h expected=%05h", ctrlOut, F0);
    end
    busy = 1'b0;
    rstN = 1'b1;
    runInstr(6'h00, 1'b0, 0, 1'b0, "R1 first fetch after reset");
    for (int op = 0; op < 64; op++) begin
      for (int z = 0; z < 2; z++) begin
        logic [5:0] prevOp;
        prevOp = opcode;
        runInstr(6'(op), 1'(z), (op + z) % 3, 1'(op & 1),
                 known(prevOp) ? "R4 return to fetch" : "R5 unknown opcode back to fetch");
      end
    end
    runInstr(6'h00, 1'b0, 0, 1'b0, "R5 unknown opcode back to fetch");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule